// File: doc/BRIEF.md
# Low-Power Wake Request Qualifier

This block decides whether a wake request seen while a single-wire bus transceiver is asleep is genuine. It samples two already-synchronized logic levels on the system clock: the digitized bus level (high = recessive, low = dominant) and an active-low local wake pin. Each input has its own duration filter. The filter length is a clock-count parameter. A nominal 50 µs is intended, with a usable range of 25 to 150 µs, scaled to the clock.

A local request qualifies once the pin has been low for the full filter length. A remote request needs more than that. The bus must first go from recessive to dominant while asleep. It must then stay dominant for at least the filter length, and it qualifies only when it returns to recessive. As a result, a bus shorted to ground never wakes the node. A qualified request produces a single-cycle pulse and a source tag, which go to the mode controller. Outside the sleep state, both filters are held cleared and no pulse is produced.

Top module: `wake_qualifier`

## Requirements
- R1: With `sleep_i` high, after the bus has been recessive, a dominant level (`bus_rec_i` = 0) sampled on BUS_FILT_CYC or more consecutive clock edges and followed by recessive gives exactly one `wake_pulse_o`, with `wake_src_o` = 0 (0 = bus). The pulse is high in the clock cycle after the edge that samples the first recessive level.
- R2: A dominant run of BUS_FILT_CYC-1 sampled edges, followed by recessive, gives no pulse.
- R3: A bus held dominant without returning to recessive never gives a pulse, however long it is held.
- R4: A dominant level that was already present when sleep was entered does not count. The bus must be seen recessive during sleep before a dominant run can qualify.
- R5: With `sleep_i` high, `wake_pin_ni` low on PIN_FILT_CYC consecutive edges gives exactly one pulse with `wake_src_o` = 1 (1 = local pin). The pulse is high in the cycle after the PIN_FILT_CYC-th low edge, and it is not repeated while the pin stays low.
- R6: A pin low run of PIN_FILT_CYC-1 edges gives no pulse.
- R7: While `sleep_i` is low, neither input produces a pulse.
- R8: Dropping `sleep_i` clears both filters, including a bus dominant run that has already reached the filter length. A release after sleep is re-entered then gives no pulse.
- R9: When bus and pin qualify in the same cycle, one pulse is produced and `wake_src_o` = 1.
- R10: Each pulse lasts exactly one clock cycle.
- R11: A filter restarts whenever its input returns to the inactive level. Two sub-threshold runs separated by one inactive cycle give no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | High while the transceiver is in its low-power state |
| bus_rec_i | input | 1 | Synchronized bus level, 1 = recessive, 0 = dominant |
| wake_pin_ni | input | 1 | Synchronized local wake pin, active low |
| wake_pulse_o | output | 1 | One-cycle qualified wake indication |
| wake_src_o | output | 1 | Source of the last wake, 0 = bus, 1 = local pin |

## Verification
The bus filter is driven with dominant runs one edge short of the threshold and exactly at it. This separates an off-by-one in the counter from correct qualification, and an exact-cycle sample pins the pulse to the release edge. Three further bus patterns show that the bus filter requires both a prior recessive level and a return to recessive rather than simple duration: a stuck-dominant bus, a bus already dominant at sleep entry, and a run that is qualified but then interrupted by leaving sleep. The pin is tried with short, threshold and split runs, to tell level counting from accumulated counting. Finally, a bus release and a pin qualification are aligned into the same cycle, to check the priority and the merging of the two into a single pulse.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef enum logic {
    SRC_BUS = 1'b0,
    SRC_PIN = 1'b1
  } wake_src_e;
endpackage

// File: rtl/wake_dur_filter.sv
module wake_dur_filter #(
  parameter int unsigned FILT_CYC     = 50,
  parameter bit          NEED_RELEASE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic active_i,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(FILT_CYC);
  localparam logic [CW-1:0] CNT_PRE = CW'(FILT_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          can_count;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || !active_i) cnt_q <= '0;
    else if (can_count && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  if (NEED_RELEASE) begin : g_release
    // an active level counts only after the idle level was seen in sleep
    logic idle_seen_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        idle_seen_q <= 1'b0;
      else if (!en_i)     idle_seen_q <= 1'b0;
      else if (!active_i) idle_seen_q <= 1'b1;
    end
    assign can_count = idle_seen_q;
    assign hit_o     = en_i & ~active_i & (cnt_q == CNT_MAX);

    // R1
    release_after_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_o |-> $past(active_i));
  end else begin : g_level
    assign can_count = 1'b1;
    assign hit_o     = en_i & active_i & (cnt_q == CNT_PRE);
  end

  // R10
  single_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> !hit_o);

  // R8
  sleep_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/wake_arb.sv
module wake_arb
  import wake_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      bus_hit_i,
  input  logic      pin_hit_i,
  output logic      pulse_o,
  output wake_src_e src_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_o <= 1'b0;
      src_o   <= SRC_BUS;
    end else begin
      pulse_o <= bus_hit_i | pin_hit_i;
      if (pin_hit_i)      src_o <= SRC_PIN;
      else if (bus_hit_i) src_o <= SRC_BUS;
    end
  end

  // R9
  pin_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_hit_i |=> (pulse_o && src_o == SRC_PIN));
endmodule

// File: rtl/wake_qualifier.sv
module wake_qualifier
  import wake_pkg::*;
#(
  parameter int unsigned BUS_FILT_CYC = 50,
  parameter int unsigned PIN_FILT_CYC = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_i,
  input  logic bus_rec_i,
  input  logic wake_pin_ni,
  output logic wake_pulse_o,
  output logic wake_src_o
);
  logic      bus_hit, pin_hit;
  wake_src_e src;

  wake_dur_filter #(
    .FILT_CYC    (BUS_FILT_CYC),
    .NEED_RELEASE(1'b1)
  ) u_bus_filt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (sleep_i),
    .active_i(~bus_rec_i),
    .hit_o   (bus_hit)
  );

  wake_dur_filter #(
    .FILT_CYC    (PIN_FILT_CYC),
    .NEED_RELEASE(1'b0)
  ) u_pin_filt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (sleep_i),
    .active_i(~wake_pin_ni),
    .hit_o   (pin_hit)
  );

  wake_arb u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bus_hit_i(bus_hit),
    .pin_hit_i(pin_hit),
    .pulse_o  (wake_pulse_o),
    .src_o    (src)
  );

  assign wake_src_o = src;

  initial begin
    filt_len_chk: assert (BUS_FILT_CYC >= 2 && PIN_FILT_CYC >= 2);
  end

  // R7
  sleep_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_pulse_o |-> $past(sleep_i));
endmodule

// File: tb/wake_qualifier_test.sv
module wake_qualifier_test;
  localparam int CLK_PERIOD = 10;
  localparam int BUS_FILT   = 50;
  localparam int PIN_FILT   = 40;
  localparam int ALIGN_D    = BUS_FILT - PIN_FILT + 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sleep_i = 1'b1;
  logic bus_rec_i = 1'b1;
  logic wake_pin_ni = 1'b1;
  logic wake_pulse_o, wake_src_o;

  int n_tests = 0;
  int n_fail  = 0;
  int pulse_cnt = 0;
  int wide_cnt  = 0;
  logic last_src = 1'b0;
  logic prev_pulse = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_qualifier #(.BUS_FILT_CYC(BUS_FILT), .PIN_FILT_CYC(PIN_FILT)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .sleep_i(sleep_i), .bus_rec_i(bus_rec_i),
    .wake_pin_ni(wake_pin_ni), .wake_pulse_o(wake_pulse_o), .wake_src_o(wake_src_o)
  );

  // sample a quarter period after each rising edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (wake_pulse_o) begin
      pulse_cnt++;
      last_src = wake_src_o;
      if (prev_pulse) wide_cnt++;
    end
    prev_pulse = wake_pulse_o;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk);
    pulse_cnt = 0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    settle(3);
    check(wake_pulse_o == 1'b0, "R10 reset pulse", int'(wake_pulse_o), 0);
    check(wake_src_o == 1'b0, "R1 reset src", int'(wake_src_o), 0);
    rst_ni = 1'b1;
    settle(3);
  endtask

  task automatic t_bus_short();
    clear_mon();
    bus_rec_i = 1'b0;
    settle(BUS_FILT - 1);
    bus_rec_i = 1'b1;
    settle(BUS_FILT + 5);
    check(pulse_cnt == 0, "R2 short dominant", pulse_cnt, 0);
  endtask

  task automatic t_bus_exact();
    clear_mon();
    bus_rec_i = 1'b0;
    settle(BUS_FILT);
    bus_rec_i = 1'b1;
    @(negedge clk);
    check(wake_pulse_o == 1'b1, "R1 pulse on release", int'(wake_pulse_o), 1);
    check(wake_src_o == 1'b0, "R1 bus source", int'(wake_src_o), 0);
    settle(BUS_FILT);
    check(pulse_cnt == 1, "R1 one bus pulse", pulse_cnt, 1);
  endtask

  task automatic t_bus_stuck_and_sleep_clear();
    clear_mon();
    bus_rec_i = 1'b0;
    settle(BUS_FILT * 4);
    check(pulse_cnt == 0, "R3 stuck dominant", pulse_cnt, 0);
    sleep_i = 1'b0;
    @(negedge clk);
    sleep_i = 1'b1;
    bus_rec_i = 1'b1;
    settle(BUS_FILT);
    check(pulse_cnt == 0, "R8 qualified run cleared by leaving sleep", pulse_cnt, 0);
  endtask

  task automatic t_bus_dom_at_entry();
    clear_mon();
    sleep_i = 1'b0;
    bus_rec_i = 1'b0;
    settle(3);
    sleep_i = 1'b1;
    settle(BUS_FILT + 10);
    bus_rec_i = 1'b1;
    settle(BUS_FILT);
    check(pulse_cnt == 0, "R4 dominant before sleep", pulse_cnt, 0);
  endtask

  task automatic t_pin_short();
    clear_mon();
    wake_pin_ni = 1'b0;
    settle(PIN_FILT - 1);
    wake_pin_ni = 1'b1;
    settle(PIN_FILT);
    check(pulse_cnt == 0, "R6 short pin low", pulse_cnt, 0);
  endtask

  task automatic t_pin_split();
    clear_mon();
    wake_pin_ni = 1'b0;
    settle(PIN_FILT - 1);
    wake_pin_ni = 1'b1;
    @(negedge clk);
    wake_pin_ni = 1'b0;
    settle(PIN_FILT - 1);
    wake_pin_ni = 1'b1;
    @(negedge clk);
    bus_rec_i = 1'b0;
    settle(BUS_FILT - 1);
    bus_rec_i = 1'b1;
    @(negedge clk);
    bus_rec_i = 1'b0;
    settle(BUS_FILT - 1);
    bus_rec_i = 1'b1;
    settle(BUS_FILT);
    check(pulse_cnt == 0, "R11 restart on idle", pulse_cnt, 0);
  endtask

  task automatic t_pin_exact();
    clear_mon();
    wake_pin_ni = 1'b0;
    settle(PIN_FILT - 1);
    check(wake_pulse_o == 1'b0, "R5 no pulse before threshold", int'(wake_pulse_o), 0);
    @(negedge clk);
    check(wake_pulse_o == 1'b1, "R5 pulse at threshold", int'(wake_pulse_o), 1);
    check(wake_src_o == 1'b1, "R5 pin source", int'(wake_src_o), 1);
    settle(PIN_FILT * 3);
    check(pulse_cnt == 1, "R5 single pulse while held", pulse_cnt, 1);
    wake_pin_ni = 1'b1;
    settle(5);
  endtask

  task automatic t_awake();
    clear_mon();
    sleep_i = 1'b0;
    wake_pin_ni = 1'b0;
    settle(PIN_FILT * 2);
    wake_pin_ni = 1'b1;
    bus_rec_i = 1'b0;
    settle(BUS_FILT * 2);
    bus_rec_i = 1'b1;
    settle(5);
    check(pulse_cnt == 0, "R7 no wake outside sleep", pulse_cnt, 0);
    sleep_i = 1'b1;
    settle(5);
  endtask

  task automatic t_simultaneous();
    clear_mon();
    bus_rec_i = 1'b0;
    settle(ALIGN_D);
    wake_pin_ni = 1'b0;
    settle(BUS_FILT - ALIGN_D);
    bus_rec_i = 1'b1;
    @(negedge clk);
    check(wake_pulse_o == 1'b1, "R9 merged pulse", int'(wake_pulse_o), 1);
    check(wake_src_o == 1'b1, "R9 pin priority", int'(wake_src_o), 1);
    settle(10);
    check(pulse_cnt == 1, "R9 single pulse", pulse_cnt, 1);
    wake_pin_ni = 1'b1;
    settle(5);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_bus_short();
    t_bus_exact();
    t_bus_stuck_and_sleep_clear();
    t_bus_dom_at_entry();
    t_pin_short();
    t_pin_split();
    t_pin_exact();
    t_awake();
    t_simultaneous();
    check(wide_cnt == 0, "R10 one-cycle pulse", wide_cnt, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule